// File: doc/BRIEF.md
# Test Status Reporting Peripheral

This block sits on a soft processor's system bus and lets self-test software report its outcome and ask for the simulation to stop. It exposes a write-only window of three 32-bit words: a halt word, a verdict word and a name-pointer word. Writing the halt word produces a one-cycle shutdown strobe. Writing the verdict word produces a one-cycle result strobe. The strobe carries a fail flag, the written code and the currently buffered test name.

Writing the name-pointer word stores an address. The block then acts as a bus master and reads the test name from memory at that address, in four word reads. While this fetch runs, the slave port is held off. Reads, partial-width writes and addresses that miss the three words are answered at once with an error response and change nothing.

Top module: `test_status_periph`

## Requirements
- R1: After reset all strobes, `busy`, `m_valid` and `s_resp_valid` are low, `s_ready` is high, and `result_code` and `result_name` are zero.
- R2: An accepted full-word write to byte offset 0x0, with any data, sets `shutdown_req` high for exactly the one cycle after acceptance, and has no other effect.
- R3: An accepted full-word write to offset 0x4 stores the data in `result_code` and pulses `result_valid` in the cycle after acceptance. `result_fail` is 0 for data zero and 1 otherwise.
- R4: An accepted full-word write of P to offset 0x8 starts exactly four master reads, issued one at a time in this order: P, P+4, P+8, P+12. Each address is held stable on `m_addr` until `m_ready`.
- R5: Name byte i (0 to 15) appears at `result_name[8*i+7:8*i]`. Bytes 0 to 14 come from memory address P+i, where read data bits [7:0] hold the byte at the lowest address of the word. Byte 15 is always zero.
- R6: From the cycle after a pointer write until the last read data is captured, `busy` is 1 and `s_ready` is 0. A verdict issued during that time is accepted only afterwards and reports the new name.
- R7: A read access (`s_write`=0) gets an error response, raises no strobe and starts no fetch.
- R8: A write whose byte enables are not all four set gets an error response and changes no state.
- R9: A write to an address that is not word-aligned or lies outside BASE..BASE+11 gets an error response and changes no state.
- R10: Every accepted access receives exactly one `s_resp_valid` pulse, in the cycle after acceptance, with `s_resp_err` marking rejection.
- R11: `result_valid` is a single-cycle pulse, and `result_name` byte 15 is zero whenever it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Slave request valid |
| s_ready | output | 1 | Slave can accept a request |
| s_write | input | 1 | 1 = write, 0 = read |
| s_addr | input | 32 | Slave byte address |
| s_be | input | 4 | Slave byte enables |
| s_wdata | input | 32 | Slave write data |
| s_resp_valid | output | 1 | Response strobe |
| s_resp_err | output | 1 | Response is an error |
| m_valid | output | 1 | Master read request valid |
| m_ready | input | 1 | Master request accepted |
| m_addr | output | 32 | Master read byte address |
| m_rvalid | input | 1 | Master read data valid |
| m_rdata | input | 32 | Master read data |
| busy | output | 1 | Name fetch in progress |
| shutdown_req | output | 1 | Shutdown request strobe |
| result_valid | output | 1 | Result event strobe |
| result_fail | output | 1 | Verdict of the stored code |
| result_code | output | 32 | Last stored verdict word |
| result_name | output | 128 | Buffered test name |

## Verification
The bench fetches names from a computed memory image at two pointers. It compares every byte against the image, so a byte-lane swap, a skipped or repeated word, or a missing terminator shows up as a name mismatch. A verdict is launched straight after a pointer write. If the block accepted that verdict early, it would report a stale or half-filled name. Reads, partial enables, misaligned offsets and out-of-window addresses are each followed by a legal verdict. A decoder that let any of them through would then show a changed name or code, a spurious strobe or an unexpected master request. The bench also checks that zero and several nonzero verdict words map to the correct fail flag.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
   localparam int unsigned TSP_NUM_REGS = 3;
   localparam int unsigned TSP_IDX_W    = 2;

   typedef enum logic [1:0] {
      SEL_HALT    = 2'd0,
      SEL_VERDICT = 2'd1,
      SEL_NAMEPTR = 2'd2,
      SEL_NONE    = 2'd3
   } tsp_sel_e;

   typedef struct packed {
      logic halt;
      logic verdict;
      logic nameptr;
      logic reject;
   } tsp_cmd_t;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_WAIT = 2'd2
   } tsp_fetch_e;
endpackage

// File: rtl/tsp_decode.sv
module tsp_decode
   import tsp_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned BE_W      = 4,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
   input  logic              accept,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BE_W-1:0]   be,
   output tsp_cmd_t          cmd
);
   localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(TSP_NUM_REGS * 4);

   logic [ADDR_W-1:0] offset;
   logic              in_win;
   logic              aligned;
   logic              full;
   logic              legal;
   tsp_sel_e          sel;

   always_comb begin
      offset  = addr - BASE_ADDR;
      in_win  = offset < WIN_BYTES;
      aligned = (addr[1:0] == 2'b00);
      full    = &be;
      legal   = wr && full && aligned && in_win;
      sel     = legal ? tsp_sel_e'(offset[TSP_IDX_W+1:2]) : SEL_NONE;
   end

   always_comb begin
      cmd         = '0;
      cmd.halt    = accept && (sel == SEL_HALT);
      cmd.verdict = accept && (sel == SEL_VERDICT);
      cmd.nameptr = accept && (sel == SEL_NAMEPTR);
      cmd.reject  = accept && (sel == SEL_NONE);
   end
endmodule

// File: rtl/tsp_events.sv
module tsp_events
   import tsp_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  tsp_cmd_t          cmd,
   input  logic [DATA_W-1:0] wdata,
   output logic              resp_valid,
   output logic              resp_err,
   output logic              shutdown,
   output logic              result_valid,
   output logic [DATA_W-1:0] code
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid   <= 1'b0;
         resp_err     <= 1'b0;
         shutdown     <= 1'b0;
         result_valid <= 1'b0;
         code         <= '0;
      end else begin
         resp_valid   <= accept;
         resp_err     <= cmd.reject;
         shutdown     <= cmd.halt;
         result_valid <= cmd.verdict;
         if (cmd.verdict) begin
            code <= wdata;
         end
      end
   end
endmodule

// File: rtl/tsp_fetch.sv
module tsp_fetch
   import tsp_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NAME_BYTES = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [ADDR_W-1:0]         start_ptr,
   output logic                      m_valid,
   input  logic                      m_ready,
   output logic [ADDR_W-1:0]         m_addr,
   input  logic                      m_rvalid,
   input  logic [DATA_W-1:0]         m_rdata,
   output logic                      busy,
   output logic [NAME_BYTES*8-1:0]   name
);
   localparam int unsigned BYTES_PER_W = DATA_W / 8;
   localparam int unsigned WORDS       = NAME_BYTES / BYTES_PER_W;
   localparam int unsigned CNT_W       = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int unsigned STEP_SH     = $clog2(BYTES_PER_W);
   localparam logic [CNT_W-1:0] LAST   = CNT_W'(WORDS - 1);

   tsp_fetch_e               state_q;
   logic [CNT_W-1:0]         cnt_q;
   logic [ADDR_W-1:0]        ptr_q;
   logic [WORDS-1:0][DATA_W-1:0] buf_q;
   logic                     capture;

   assign capture = (state_q == FS_WAIT) && m_rvalid;
   assign m_valid = (state_q == FS_REQ);
   assign m_addr  = ptr_q + (ADDR_W'(cnt_q) << STEP_SH);
   assign busy    = (state_q != FS_IDLE);
   assign name    = buf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         cnt_q   <= '0;
         ptr_q   <= '0;
      end else begin
         case (state_q)
            FS_IDLE: begin
               if (start) begin
                  ptr_q   <= start_ptr;
                  cnt_q   <= '0;
                  state_q <= FS_REQ;
               end
            end
            FS_REQ: begin
               if (m_ready) begin
                  state_q <= FS_WAIT;
               end
            end
            FS_WAIT: begin
               if (m_rvalid) begin
                  if (cnt_q == LAST) begin
                     state_q <= FS_IDLE;
                  end else begin
                     cnt_q   <= cnt_q + 1'b1;
                     state_q <= FS_REQ;
                  end
               end
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      if (w == WORDS - 1) begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               buf_q[w] <= '0;
            end else if (capture && cnt_q == CNT_W'(w)) begin
               buf_q[w] <= {8'h00, m_rdata[DATA_W-9:0]};
            end
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               buf_q[w] <= '0;
            end else if (capture && cnt_q == CNT_W'(w)) begin
               buf_q[w] <= m_rdata;
            end
         end
      end
   end
endmodule

// File: rtl/test_status_periph.sv
module test_status_periph
   import tsp_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NAME_BYTES = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    s_valid,
   output logic                    s_ready,
   input  logic                    s_write,
   input  logic [ADDR_W-1:0]       s_addr,
   input  logic [DATA_W/8-1:0]     s_be,
   input  logic [DATA_W-1:0]       s_wdata,
   output logic                    s_resp_valid,
   output logic                    s_resp_err,
   output logic                    m_valid,
   input  logic                    m_ready,
   output logic [ADDR_W-1:0]       m_addr,
   input  logic                    m_rvalid,
   input  logic [DATA_W-1:0]       m_rdata,
   output logic                    busy,
   output logic                    shutdown_req,
   output logic                    result_valid,
   output logic                    result_fail,
   output logic [DATA_W-1:0]       result_code,
   output logic [NAME_BYTES*8-1:0] result_name
);
   localparam int unsigned BE_W = DATA_W / 8;

   if (DATA_W != 32) begin : g_bad_data
      $error("test_status_periph: DATA_W must be 32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("test_status_periph: ADDR_W too small");
   end
   if (NAME_BYTES % BE_W != 0 || NAME_BYTES / BE_W < 2) begin : g_bad_name
      $error("test_status_periph: NAME_BYTES must be a multiple of the word size, two words or more");
   end
   if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_base
      $error("test_status_periph: BASE_ADDR must be word aligned");
   end

   logic     accept;
   tsp_cmd_t cmd;

   assign s_ready = !busy;
   assign accept  = s_valid && s_ready;

   tsp_decode #(
      .ADDR_W   (ADDR_W),
      .BE_W     (BE_W),
      .BASE_ADDR(BASE_ADDR)
   ) u_decode (
      .accept(accept),
      .wr    (s_write),
      .addr  (s_addr),
      .be    (s_be),
      .cmd   (cmd)
   );

   tsp_events #(
      .DATA_W(DATA_W)
   ) u_events (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .cmd         (cmd),
      .wdata       (s_wdata),
      .resp_valid  (s_resp_valid),
      .resp_err    (s_resp_err),
      .shutdown    (shutdown_req),
      .result_valid(result_valid),
      .code        (result_code)
   );

   assign result_fail = |result_code;

   tsp_fetch #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NAME_BYTES(NAME_BYTES)
   ) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (cmd.nameptr),
      .start_ptr(s_wdata[ADDR_W-1:0]),
      .m_valid  (m_valid),
      .m_ready  (m_ready),
      .m_addr   (m_addr),
      .m_rvalid (m_rvalid),
      .m_rdata  (m_rdata),
      .busy     (busy),
      .name     (result_name)
   );
endmodule

// File: rtl/tsp_checker.sv
module tsp_checker #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned NAME_W = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_valid,
   input logic              s_ready,
   input logic              s_resp_valid,
   input logic              s_resp_err,
   input logic              m_valid,
   input logic              m_ready,
   input logic [ADDR_W-1:0] m_addr,
   input logic              busy,
   input logic              shutdown_req,
   input logic              result_valid,
   input logic [NAME_W-1:0] result_name
);
   // R2
   shutdown_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |=> !shutdown_req);

   // R11
   result_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   // R11
   result_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> (result_name[NAME_W-1 -: 8] == 8'h00));

   // R6
   hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !s_ready);

   // R10
   resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |=> s_resp_valid);

   // R10
   resp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_valid && s_ready) |=> !s_resp_valid);

   // R4
   master_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_addr)));

   // R7
   reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_resp_valid && s_resp_err) |-> (!shutdown_req && !result_valid));
endmodule

bind test_status_periph tsp_checker #(
   .ADDR_W(ADDR_W),
   .NAME_W(NAME_BYTES * 8)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .s_valid     (s_valid),
   .s_ready     (s_ready),
   .s_resp_valid(s_resp_valid),
   .s_resp_err  (s_resp_err),
   .m_valid     (m_valid),
   .m_ready     (m_ready),
   .m_addr      (m_addr),
   .busy        (busy),
   .shutdown_req(shutdown_req),
   .result_valid(result_valid),
   .result_name (result_name)
);

// File: tb/sim_test_status_periph.sv
module sim_test_status_periph;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BASE = 32'hFFFF_0000;
   localparam int WATCHDOG = 20000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         s_valid = 1'b0;
   logic         s_ready;
   logic         s_write = 1'b0;
   logic [31:0]  s_addr = '0;
   logic [3:0]   s_be = '0;
   logic [31:0]  s_wdata = '0;
   logic         s_resp_valid;
   logic         s_resp_err;
   logic         m_valid;
   logic         m_ready = 1'b1;
   logic [31:0]  m_addr;
   logic         m_rvalid = 1'b0;
   logic [31:0]  m_rdata = '0;
   logic         busy;
   logic         shutdown_req;
   logic         result_valid;
   logic         result_fail;
   logic [31:0]  result_code;
   logic [127:0] result_name;

   int n_checks = 0;
   int n_fail = 0;
   int n_fetch = 0;
   logic [31:0] fetch_log [0:15];
   logic timed_out = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   test_status_periph u0 (
      .clk(clk), .rst_n(rst_n),
      .s_valid(s_valid), .s_ready(s_ready), .s_write(s_write),
      .s_addr(s_addr), .s_be(s_be), .s_wdata(s_wdata),
      .s_resp_valid(s_resp_valid), .s_resp_err(s_resp_err),
      .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr),
      .m_rvalid(m_rvalid), .m_rdata(m_rdata),
      .busy(busy), .shutdown_req(shutdown_req),
      .result_valid(result_valid), .result_fail(result_fail),
      .result_code(result_code), .result_name(result_name)
   );

   function automatic logic [7:0] mem_byte(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A ^ {a[3:0], 4'h1};
   endfunction

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return {mem_byte(a + 32'd3), mem_byte(a + 32'd2), mem_byte(a + 32'd1), mem_byte(a)};
   endfunction

   function automatic logic [127:0] exp_name(input logic [31:0] p);
      logic [127:0] n;
      n = '0;
      for (int i = 0; i < 15; i++) n[8*i +: 8] = mem_byte(p + 32'(i));
      return n;
   endfunction

   // memory model answering the master port
   initial begin
      @(negedge clk);
      forever begin
         if (m_valid && m_ready) begin
            if (n_fetch < 16) fetch_log[n_fetch] = m_addr;
            n_fetch++;
            @(negedge clk);
            m_rvalid = 1'b1;
            m_rdata  = mem_word(fetch_log[(n_fetch - 1) % 16]);
            @(negedge clk);
            m_rvalid = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
   end

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // captured values in the cycle after acceptance and the one after that
   logic c_rv, c_re, c_sd, c_res, c_fail;
   logic [31:0] c_code;
   logic [127:0] c_name;
   logic d_rv, d_sd, d_res;

   task automatic bus_acc(input logic wr, input logic [31:0] a, input logic [3:0] be,
                          input logic [31:0] d);
      @(negedge clk);
      s_valid = 1'b1; s_write = wr; s_addr = a; s_be = be; s_wdata = d;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0; s_write = 1'b0; s_addr = '0; s_be = '0; s_wdata = '0;
      c_rv = s_resp_valid; c_re = s_resp_err; c_sd = shutdown_req;
      c_res = result_valid; c_fail = result_fail; c_code = result_code; c_name = result_name;
      @(negedge clk);
      d_rv = s_resp_valid; d_sd = shutdown_req; d_res = result_valid;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 shutdown", 128'(shutdown_req), 0);
      chk("R1 result_valid", 128'(result_valid), 0);
      chk("R1 busy", 128'(busy), 0);
      chk("R1 s_ready", 128'(s_ready), 1);
      chk("R1 m_valid", 128'(m_valid), 0);
      chk("R1 resp", 128'(s_resp_valid), 0);
      chk("R1 code", 128'(result_code), 0);
      chk("R1 name", result_name, 0);
   endtask

   task automatic t_verdict(input logic [31:0] v, input logic [127:0] name);
      bus_acc(1'b1, BASE + 32'h4, 4'hF, v);
      chk("R3 pulse", 128'(c_res), 1);
      chk("R3 fail flag", 128'(c_fail), 128'(v != 0));
      chk("R3 code", 128'(c_code), 128'(v));
      chk("R5 name", c_name, name);
      chk("R10 resp ok", 128'({c_rv, c_re}), 128'(2'b10));
      chk("R11 one cycle", 128'(d_res), 0);
      chk("R10 single resp", 128'(d_rv), 0);
   endtask

   task automatic t_halt(input logic [31:0] v);
      bus_acc(1'b1, BASE, 4'hF, v);
      chk("R2 shutdown", 128'(c_sd), 1);
      chk("R2 no result", 128'(c_res), 0);
      chk("R2 one cycle", 128'(d_sd), 0);
      chk("R10 resp ok", 128'({c_rv, c_re}), 128'(2'b10));
   endtask

   task automatic t_fetch(input logic [31:0] p);
      int base_n;
      base_n = n_fetch;
      bus_acc(1'b1, BASE + 32'h8, 4'hF, p);
      chk("R6 busy", 128'(busy), 1);
      chk("R6 s_ready low", 128'(s_ready), 0);
      wait_idle();
      @(negedge clk);
      chk("R4 read count", 128'(n_fetch - base_n), 4);
      for (int k = 0; k < 4; k++)
         chk("R4 read addr", 128'(fetch_log[(base_n + k) % 16]), 128'(p + 32'(4 * k)));
   endtask

   task automatic t_held_verdict(input logic [31:0] p, input logic [31:0] v);
      bus_acc(1'b1, BASE + 32'h8, 4'hF, p);
      bus_acc(1'b1, BASE + 32'h4, 4'hF, v);
      chk("R6 held verdict name", c_name, exp_name(p));
      chk("R6 held verdict code", 128'(c_code), 128'(v));
   endtask

   task automatic t_reject(input string req, input logic wr, input logic [31:0] a,
                           input logic [3:0] be, input logic [31:0] d);
      int base_n;
      base_n = n_fetch;
      bus_acc(wr, a, be, d);
      chk({req, " err resp"}, 128'({c_rv, c_re}), 128'(2'b11));
      chk({req, " no strobe"}, 128'({c_sd, c_res}), 0);
      chk({req, " no fetch"}, 128'({busy, m_valid}), 0);
      repeat (3) @(negedge clk);
      chk({req, " no reads"}, 128'(n_fetch - base_n), 0);
   endtask

   task automatic run_all();
      logic [127:0] cur;
      t_reset();
      t_verdict(32'h0, 128'h0);                 // R1 name still clear
      t_halt(32'hDEAD_BEEF);
      t_halt(32'h0);
      t_fetch(32'h0000_1000);
      cur = exp_name(32'h0000_1000);
      t_verdict(32'h0000_0007, cur);
      t_verdict(32'h8000_0000, cur);
      t_verdict(32'h0, cur);
      t_fetch(32'h0002_34A0);
      cur = exp_name(32'h0002_34A0);
      t_verdict(32'hFFFF_FFFF, cur);
      t_held_verdict(32'h0000_5550, 32'h0000_0001);
      cur = exp_name(32'h0000_5550);
      // R7 reads are rejected
      t_reject("R7", 1'b0, BASE + 32'h8, 4'hF, 32'h0000_9000);
      t_reject("R7", 1'b0, BASE, 4'hF, 32'h0);
      // R8 partial enables
      t_reject("R8", 1'b1, BASE + 32'h8, 4'b0111, 32'h0000_9000);
      t_reject("R8", 1'b1, BASE, 4'b0001, 32'h1);
      t_reject("R8", 1'b1, BASE + 32'h4, 4'b1100, 32'h3);
      // R9 misaligned and out of window
      t_reject("R9", 1'b1, BASE + 32'h9, 4'hF, 32'h0000_9000);
      t_reject("R9", 1'b1, BASE + 32'hC, 4'hF, 32'h0000_9000);
      t_reject("R9", 1'b1, 32'h0000_0008, 4'hF, 32'h0000_9000);
      t_reject("R9", 1'b1, BASE - 32'h4, 4'hF, 32'h0000_9000);
      // R8 R9 state unchanged: code from last legal verdict, name from last fetch
      chk("R8 code kept", 128'(result_code), 128'(32'h1));
      t_verdict(32'h0000_0000, cur);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      fork
         run_all();
         begin
            repeat (WATCHDOG) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=expired expected=finished");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule